// File: doc/BRIEF.md
# Straddled Request Stream Checker

This block is a passive monitor placed beside a 512-bit request stream that uses a valid/ready handshake. It never drives the stream. It evaluates every beat that is accepted (valid and ready both high) against the framing rules of the selected mode. In non-straddle mode, packets are framed by a last flag and 16 per-Dword keep bits. In straddle mode, up to two packets may open and up to two may close inside one beat. These are marked by a 2-bit start code, a 2-bit end code, two start pointers and two end pointers. Independently of the mode, it also watches stalled beats (valid high, ready low) for stability.

Each rule owns one bit of a sticky error vector. A code output names the lowest-numbered rule broken by the most recent offending beat. Two small state machines per mode track framing: `FR_CLOSED` moves to `FR_OPEN` when a packet starts and is not finished in that beat, and `FR_OPEN` moves back to `FR_CLOSED` on the beat that finishes it. A handshake state machine moves from `HS_FREE` to `HS_STALLED` when valid is high while ready is low. It stays in `HS_STALLED` while that persists and returns to `HS_FREE` on any cycle without a stall. On entry it captures a snapshot of the beat, which later stalled cycles are compared against.

Top module: `rq_straddle_checker`

## Requirements
- R1: After reset, err_flags and err_code are 0 and both pkt_open_ns and pkt_open_st are 0.
- R2: In straddle mode, start_code encodes 00 = none, 01 = one start, 11 = two starts; the value 10 sets err_flags bit 0.
- R3: In straddle mode, start_ptr0 must be 00 or 10 whenever start_code bit 0 is set, and start_ptr1 must be 10 when start_code is 11; any other value sets err_flags bit 1.
- R4: In straddle mode, end_code 10 sets err_flags bit 2. When end_code is 11, end_ptr1 must be greater than end_ptr0, otherwise bit 3 is set.
- R5: In non-straddle mode, beat_keep must be contiguous ones from bit 0 and must be all ones on any beat without beat_last; a violation sets err_flags bit 4.
- R6: A start while a packet is still open sets bit 5, and an end with no packet open sets bit 6. In straddle mode, ends and starts alternate inside a beat, the end of an open packet coming first. pkt_open_ns and pkt_open_st report the open state of each mode.
- R7: In non-straddle mode, start_code bit 0 starts a packet and beat_last ends it (both may be set on one beat). An accepted beat with no packet open and start_code bit 0 low sets bit 7.
- R8: abort on a beat where no packet was open before the beat (the first beat of a packet) sets bit 8.
- R9: In straddle mode, abort together with a nonzero end_code and a nonzero start_code in one beat sets bit 9.
- R10: After a stalled cycle, valid dropping or any change of data, keep, last, codes or pointers before ready sets bit 10. abort going from high to low while stalled sets bit 11.
- R11: Rules R2 to R9 are evaluated only on accepted beats, and straddle_en selects which rule set and which open flag apply.
- R12: err_flags bits stay set until reset or clr_err, and clr_err wins over a violation in the same cycle. err_code takes the lowest violated bit index of each offending cycle, holds otherwise, and is cleared by clr_err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr_err | input | 1 | Clears err_flags and err_code |
| straddle_en | input | 1 | 1 = straddle mode, 0 = non-straddle mode |
| beat_valid | input | 1 | Stream valid |
| beat_ready | input | 1 | Stream ready |
| beat_data | input | 512 | Stream data (stability only) |
| beat_keep | input | 16 | Per-Dword keep bits |
| beat_last | input | 1 | Last beat flag (non-straddle) |
| start_code | input | 2 | Packet start code |
| start_ptr0 | input | 2 | Position of first starting packet |
| start_ptr1 | input | 2 | Position of second starting packet |
| end_code | input | 2 | Packet end code |
| end_ptr0 | input | 4 | Last Dword of first ending packet |
| end_ptr1 | input | 4 | Last Dword of second ending packet |
| abort | input | 1 | Discontinue request for the packet in flight |
| err_flags | output | 12 | Sticky per-rule error bits |
| err_code | output | 4 | Lowest rule index of the latest offending cycle |
| err_any | output | 1 | OR of err_flags |
| pkt_open_ns | output | 1 | Packet open in non-straddle tracking |
| pkt_open_st | output | 1 | Packet open in straddle tracking |

## Verification
Two functions can fall in one cycle. The first is a straddle beat that closes an open packet, starts a new one and carries abort. That beat must raise only the abort-with-start rule while the open flag stays set. The bench drives it after opening a packet and judges the exact flag vector and code. The second is clr_err arriving on the same cycle as a malformed beat. The bench provokes it with a beat that breaks two rules at once and checks that the flags read zero afterwards. Before that, it checks that a two-rule beat reports the lower index as the code and that a later violation updates the code without dropping the earlier bits.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
    localparam int RULE_N = 12;
    localparam int CODE_W = $clog2(RULE_N);

    localparam int R_START_RSVD  = 0;
    localparam int R_START_PTR   = 1;
    localparam int R_END_RSVD    = 2;
    localparam int R_END_ORDER   = 3;
    localparam int R_KEEP        = 4;
    localparam int R_START_OPEN  = 5;
    localparam int R_END_CLOSED  = 6;
    localparam int R_NO_START    = 7;
    localparam int R_ABORT_FIRST = 8;
    localparam int R_ABORT_START = 9;
    localparam int R_HOLD        = 10;
    localparam int R_ABORT_DROP  = 11;

    typedef logic [RULE_N-1:0] rule_vec_t;

    typedef enum logic {FR_CLOSED = 1'b0, FR_OPEN = 1'b1} frame_st_t;
    typedef enum logic {HS_FREE = 1'b0, HS_STALLED = 1'b1} hs_st_t;
endpackage

// File: rtl/sfc_ns_rules.sv
module sfc_ns_rules
    import sfc_pkg::*;
#(
    parameter int KEEP_W = 16
) (
    input  frame_st_t         cur_st,
    input  logic [KEEP_W-1:0] keep,
    input  logic              last,
    input  logic              start0,
    input  logic              abort,
    output rule_vec_t         viol,
    output frame_st_t         nxt_st
);
    logic contig;

    always_comb begin
        contig = keep[0] && ((keep & (keep + KEEP_W'(1))) == '0);
        viol   = '0;
        if (!contig || (!last && (keep != '1))) viol[R_KEEP] = 1'b1;
        if ((cur_st == FR_OPEN) && start0)      viol[R_START_OPEN] = 1'b1;
        if ((cur_st == FR_CLOSED) && !start0)   viol[R_NO_START] = 1'b1;
        if (abort && (cur_st == FR_CLOSED))     viol[R_ABORT_FIRST] = 1'b1;
        nxt_st = last ? FR_CLOSED : FR_OPEN;
    end
endmodule

// File: rtl/sfc_st_rules.sv
module sfc_st_rules
    import sfc_pkg::*;
#(
    parameter int PTR_W = 4
) (
    input  frame_st_t        cur_st,
    input  logic [1:0]       start_code,
    input  logic [1:0]       start_ptr0,
    input  logic [1:0]       start_ptr1,
    input  logic [1:0]       end_code,
    input  logic [PTR_W-1:0] end_ptr0,
    input  logic [PTR_W-1:0] end_ptr1,
    input  logic             abort,
    output rule_vec_t        viol,
    output frame_st_t        nxt_st
);
    int n_start;
    int n_end;
    int balance;

    function automatic int code_count(input logic [1:0] c);
        unique case (c)
            2'b01:   return 1;
            2'b11:   return 2;
            default: return 0;
        endcase
    endfunction

    always_comb begin
        n_start = code_count(start_code);
        n_end   = code_count(end_code);
        balance = ((cur_st == FR_OPEN) ? 1 : 0) + n_start - n_end;
        viol    = '0;
        if (start_code == 2'b10) viol[R_START_RSVD] = 1'b1;
        if ((start_code[0] && (start_ptr0 != 2'b00) && (start_ptr0 != 2'b10)) ||
            ((start_code == 2'b11) && (start_ptr1 != 2'b10)))
            viol[R_START_PTR] = 1'b1;
        if (end_code == 2'b10) viol[R_END_RSVD] = 1'b1;
        if ((end_code == 2'b11) && (end_ptr1 <= end_ptr0)) viol[R_END_ORDER] = 1'b1;
        if (balance > 1) viol[R_START_OPEN] = 1'b1;
        if (balance < 0) viol[R_END_CLOSED] = 1'b1;
        if (abort && (cur_st == FR_CLOSED)) viol[R_ABORT_FIRST] = 1'b1;
        if (abort && (end_code != 2'b00) && (start_code != 2'b00)) viol[R_ABORT_START] = 1'b1;
        nxt_st = (balance >= 1) ? FR_OPEN : FR_CLOSED;
    end
endmodule

// File: rtl/sfc_hold_watch.sv
module sfc_hold_watch
    import sfc_pkg::*;
#(
    parameter int BUNDLE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                valid,
    input  logic                ready,
    input  logic [BUNDLE_W-1:0] bundle,
    input  logic                abort,
    output logic                hold_viol,
    output logic                drop_viol
);
    hs_st_t              st_q, st_d;
    logic [BUNDLE_W-1:0] snap_q;
    logic                snap_abort_q;

    always_comb begin
        st_d = (valid && !ready) ? HS_STALLED : HS_FREE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q         <= HS_FREE;
            snap_q       <= '0;
            snap_abort_q <= 1'b0;
        end else begin
            st_q <= st_d;
            if ((st_q == HS_FREE) && (st_d == HS_STALLED)) begin
                snap_q       <= bundle;
                snap_abort_q <= abort;
            end
        end
    end

    always_comb begin
        hold_viol = 1'b0;
        drop_viol = 1'b0;
        unique case (st_q)
            HS_STALLED: begin
                hold_viol = !valid || (bundle != snap_q);
                drop_viol = snap_abort_q && !abort;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/rq_straddle_checker.sv
module rq_straddle_checker
    import sfc_pkg::*;
#(
    parameter int DATA_W = 512,
    parameter int KEEP_W = DATA_W / 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        clr_err,
    input  logic                        straddle_en,
    input  logic                        beat_valid,
    input  logic                        beat_ready,
    input  logic [DATA_W-1:0]           beat_data,
    input  logic [KEEP_W-1:0]           beat_keep,
    input  logic                        beat_last,
    input  logic [1:0]                  start_code,
    input  logic [1:0]                  start_ptr0,
    input  logic [1:0]                  start_ptr1,
    input  logic [1:0]                  end_code,
    input  logic [$clog2(KEEP_W)-1:0]   end_ptr0,
    input  logic [$clog2(KEEP_W)-1:0]   end_ptr1,
    input  logic                        abort,
    output logic [RULE_N-1:0]           err_flags,
    output logic [CODE_W-1:0]           err_code,
    output logic                        err_any,
    output logic                        pkt_open_ns,
    output logic                        pkt_open_st
);
    localparam int PTR_W    = $clog2(KEEP_W);
    localparam int BUNDLE_W = DATA_W + KEEP_W + 1 + 8 + 2 * PTR_W;

    frame_st_t ns_q, ns_d, st_q, st_d;
    rule_vec_t ns_viol, st_viol, new_viol, flags_q;
    logic [CODE_W-1:0] code_q;
    logic accepted, hold_viol, drop_viol;
    logic [BUNDLE_W-1:0] bundle;

    assign accepted = beat_valid && beat_ready;
    assign bundle   = {beat_data, beat_keep, beat_last, start_code, start_ptr0,
                       start_ptr1, end_code, end_ptr0, end_ptr1};

    sfc_ns_rules #(.KEEP_W(KEEP_W)) u_ns (
        .cur_st(ns_q), .keep(beat_keep), .last(beat_last), .start0(start_code[0]),
        .abort(abort), .viol(ns_viol), .nxt_st(ns_d)
    );

    sfc_st_rules #(.PTR_W(PTR_W)) u_st (
        .cur_st(st_q), .start_code(start_code), .start_ptr0(start_ptr0),
        .start_ptr1(start_ptr1), .end_code(end_code), .end_ptr0(end_ptr0),
        .end_ptr1(end_ptr1), .abort(abort), .viol(st_viol), .nxt_st(st_d)
    );

    sfc_hold_watch #(.BUNDLE_W(BUNDLE_W)) u_hold (
        .clk(clk), .rst_n(rst_n), .valid(beat_valid), .ready(beat_ready),
        .bundle(bundle), .abort(abort), .hold_viol(hold_viol), .drop_viol(drop_viol)
    );

    function automatic logic [CODE_W-1:0] lowest_set(input rule_vec_t v);
        logic [CODE_W-1:0] c;
        c = '0;
        for (int i = RULE_N - 1; i >= 0; i--) begin
            if (v[i]) c = CODE_W'(i);
        end
        return c;
    endfunction

    always_comb begin
        new_viol = '0;
        if (accepted) new_viol = straddle_en ? st_viol : ns_viol;
        new_viol[R_HOLD]       = new_viol[R_HOLD] | hold_viol;
        new_viol[R_ABORT_DROP] = new_viol[R_ABORT_DROP] | drop_viol;
    end

    // state register for framing and the sticky error record
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ns_q    <= FR_CLOSED;
            st_q    <= FR_CLOSED;
            flags_q <= '0;
            code_q  <= '0;
        end else begin
            if (accepted && !straddle_en) ns_q <= ns_d;
            if (accepted && straddle_en)  st_q <= st_d;
            if (clr_err) begin
                flags_q <= '0;
                code_q  <= '0;
            end else if (new_viol != '0) begin
                flags_q <= flags_q | new_viol;
                code_q  <= lowest_set(new_viol);
            end
        end
    end

    // outputs
    always_comb begin
        err_flags   = flags_q;
        err_code    = code_q;
        err_any     = |flags_q;
        pkt_open_ns = (ns_q == FR_OPEN);
        pkt_open_st = (st_q == FR_OPEN);
    end

    p_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_err |=> ((err_flags & $past(err_flags)) == $past(err_flags)));

    p_clear_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
        clr_err |=> (err_flags == '0) && (err_code == '0));

    p_start_rsvd_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && beat_ready && straddle_en && (start_code == 2'b10) && !clr_err)
        |=> err_flags[R_START_RSVD]);

    p_open_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && beat_ready && straddle_en && !pkt_open_st &&
         (start_code == 2'b01) && (end_code == 2'b00)) |=> pkt_open_st);

    p_valid_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && !beat_ready) ##1 (!beat_valid && !clr_err) |=> err_flags[R_HOLD]);
endmodule

// File: tb/sim_rq_straddle_checker.sv
module sim_rq_straddle_checker;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n, clr_err, straddle_en, beat_valid, beat_ready, beat_last, abort;
    logic [511:0] beat_data;
    logic [15:0]  beat_keep;
    logic [1:0]   start_code, start_ptr0, start_ptr1, end_code;
    logic [3:0]   end_ptr0, end_ptr1;
    logic [11:0]  err_flags;
    logic [3:0]   err_code;
    logic         err_any, pkt_open_ns, pkt_open_st;

    int n_checks = 0;
    int n_errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    rq_straddle_checker u0 (
        .clk(clk), .rst_n(rst_n), .clr_err(clr_err), .straddle_en(straddle_en),
        .beat_valid(beat_valid), .beat_ready(beat_ready), .beat_data(beat_data),
        .beat_keep(beat_keep), .beat_last(beat_last), .start_code(start_code),
        .start_ptr0(start_ptr0), .start_ptr1(start_ptr1), .end_code(end_code),
        .end_ptr0(end_ptr0), .end_ptr1(end_ptr1), .abort(abort),
        .err_flags(err_flags), .err_code(err_code), .err_any(err_any),
        .pkt_open_ns(pkt_open_ns), .pkt_open_st(pkt_open_st)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        beat_valid = 1'b0; beat_ready = 1'b1; beat_last = 1'b0; abort = 1'b0;
        beat_keep = 16'hffff; start_code = 2'b00; start_ptr0 = 2'b00; start_ptr1 = 2'b00;
        end_code = 2'b00; end_ptr0 = 4'd0; end_ptr1 = 4'd0; clr_err = 1'b0;
    endtask

    task automatic do_reset(input logic mode);
        @(negedge clk);
        rst_n = 1'b0; idle(); straddle_en = mode;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic ns_beat(input logic s0, input logic [15:0] k, input logic l, input logic ab);
        beat_valid = 1'b1; beat_ready = 1'b1; start_code = {1'b0, s0};
        beat_keep = k; beat_last = l; abort = ab;
        beat_data = {16{32'hA5A5_0000 + 32'(k)}};
        @(negedge clk);
        beat_valid = 1'b0; abort = 1'b0;
    endtask

    task automatic st_beat(input logic [1:0] sc, input logic [1:0] p0, input logic [1:0] p1,
                           input logic [1:0] ec, input logic [3:0] e0, input logic [3:0] e1,
                           input logic ab);
        beat_valid = 1'b1; beat_ready = 1'b1; start_code = sc; start_ptr0 = p0;
        start_ptr1 = p1; end_code = ec; end_ptr0 = e0; end_ptr1 = e1; abort = ab;
        @(negedge clk);
        beat_valid = 1'b0; abort = 1'b0; start_code = 2'b00; end_code = 2'b00;
    endtask

    task automatic t_reset();
        do_reset(1'b0);
        chk("R1 flags", 32'(err_flags), 0);
        chk("R1 code", 32'(err_code), 0);
        chk("R1 open_ns", 32'(pkt_open_ns), 0);
        chk("R1 open_st", 32'(pkt_open_st), 0);
    endtask

    task automatic t_ns_frames();
        do_reset(1'b0);
        ns_beat(1'b1, 16'hffff, 1'b0, 1'b0);
        chk("R6 ns open after start", 32'(pkt_open_ns), 1);
        ns_beat(1'b0, 16'hffff, 1'b0, 1'b0);
        ns_beat(1'b0, 16'h00ff, 1'b1, 1'b0);
        chk("R6 ns closed after last", 32'(pkt_open_ns), 0);
        ns_beat(1'b1, 16'h000f, 1'b1, 1'b0);
        chk("R7 single-beat packet clean", 32'(err_flags), 0);
        chk("R7 closed after single beat", 32'(pkt_open_ns), 0);
        beat_keep = 16'h0f0f; start_code = 2'b10;
        @(negedge clk);
        chk("R11 idle garbage ignored", 32'(err_flags), 0);
    endtask

    task automatic t_ns_errors();
        do_reset(1'b0);
        ns_beat(1'b1, 16'h00f0, 1'b1, 1'b0);
        chk("R5 keep gap flags", 32'(err_flags), 32'h010);
        chk("R5 keep gap code", 32'(err_code), 4);
        do_reset(1'b0);
        ns_beat(1'b1, 16'h7fff, 1'b0, 1'b0);
        chk("R5 partial keep not last", 32'(err_flags), 32'h010);
        do_reset(1'b0);
        ns_beat(1'b0, 16'h000f, 1'b1, 1'b0);
        chk("R7 missing start flags", 32'(err_flags), 32'h080);
        chk("R7 missing start code", 32'(err_code), 7);
        do_reset(1'b0);
        ns_beat(1'b1, 16'hffff, 1'b0, 1'b0);
        ns_beat(1'b1, 16'hffff, 1'b0, 1'b0);
        chk("R6 ns start while open", 32'(err_flags), 32'h020);
    endtask

    task automatic t_stall_gate();
        do_reset(1'b0);
        beat_valid = 1'b1; beat_ready = 1'b0; start_code = 2'b01;
        beat_keep = 16'h00f0; beat_last = 1'b1;
        @(negedge clk);
        chk("R11 stalled bad beat not judged", 32'(err_flags), 0);
        @(negedge clk);
        chk("R11 stalled stable beat", 32'(err_flags), 0);
        beat_ready = 1'b1;
        @(negedge clk);
        beat_valid = 1'b0;
        chk("R11 judged on accept", 32'(err_flags), 32'h010);
    endtask

    task automatic t_st_frames();
        do_reset(1'b1);
        st_beat(2'b11, 2'b00, 2'b10, 2'b01, 4'd7, 4'd0, 1'b0);
        chk("R2 two starts one end clean", 32'(err_flags), 0);
        chk("R6 straddle open", 32'(pkt_open_st), 1);
        chk("R11 ns flag untouched in straddle", 32'(pkt_open_ns), 0);
        st_beat(2'b01, 2'b10, 2'b00, 2'b01, 4'd3, 4'd0, 1'b0);
        chk("R3 end then start clean", 32'(err_flags), 0);
        chk("R6 still open", 32'(pkt_open_st), 1);
        st_beat(2'b00, 2'b00, 2'b00, 2'b11, 4'd5, 4'd9, 1'b0);
        chk("R6 two ends over open plus none", 32'(err_flags), 32'h040);
    endtask

    task automatic t_st_codes();
        do_reset(1'b1);
        st_beat(2'b10, 2'b00, 2'b00, 2'b00, 4'd0, 4'd0, 1'b0);
        chk("R2 reserved start flags", 32'(err_flags), 32'h001);
        chk("R2 reserved start code", 32'(err_code), 0);
        do_reset(1'b1);
        st_beat(2'b01, 2'b01, 2'b00, 2'b00, 4'd0, 4'd0, 1'b0);
        chk("R3 bad first pointer", 32'(err_flags), 32'h002);
        do_reset(1'b1);
        st_beat(2'b11, 2'b00, 2'b00, 2'b01, 4'd4, 4'd0, 1'b0);
        chk("R3 bad second pointer", 32'(err_flags), 32'h002);
        do_reset(1'b1);
        st_beat(2'b00, 2'b00, 2'b00, 2'b10, 4'd0, 4'd0, 1'b0);
        chk("R4 reserved end", 32'(err_flags), 32'h004);
        do_reset(1'b1);
        st_beat(2'b01, 2'b00, 2'b00, 2'b00, 4'd0, 4'd0, 1'b0);
        st_beat(2'b01, 2'b10, 2'b00, 2'b11, 4'd9, 4'd3, 1'b0);
        chk("R4 end pointers out of order", 32'(err_flags), 32'h008);
        chk("R4 order code", 32'(err_code), 3);
    endtask

    task automatic t_st_balance();
        do_reset(1'b1);
        st_beat(2'b00, 2'b00, 2'b00, 2'b01, 4'd2, 4'd0, 1'b0);
        chk("R6 end with none open", 32'(err_flags), 32'h040);
        chk("R6 end none code", 32'(err_code), 6);
        do_reset(1'b1);
        st_beat(2'b01, 2'b00, 2'b00, 2'b00, 4'd0, 4'd0, 1'b0);
        st_beat(2'b01, 2'b00, 2'b00, 2'b00, 4'd0, 4'd0, 1'b0);
        chk("R6 straddle start while open", 32'(err_flags), 32'h020);
    endtask

    task automatic t_abort();
        do_reset(1'b0);
        ns_beat(1'b1, 16'hffff, 1'b0, 1'b1);
        chk("R8 abort on first beat", 32'(err_flags), 32'h100);
        chk("R8 abort code", 32'(err_code), 8);
        do_reset(1'b0);
        ns_beat(1'b1, 16'hffff, 1'b0, 1'b0);
        ns_beat(1'b0, 16'hffff, 1'b1, 1'b1);
        chk("R8 abort on later beat legal", 32'(err_flags), 0);
        do_reset(1'b1);
        st_beat(2'b01, 2'b00, 2'b00, 2'b00, 4'd0, 4'd0, 1'b0);
        st_beat(2'b01, 2'b10, 2'b00, 2'b01, 4'd3, 4'd0, 1'b1);
        chk("R9 abort with start", 32'(err_flags), 32'h200);
        chk("R9 abort with start code", 32'(err_code), 9);
        chk("R9 new packet still open", 32'(pkt_open_st), 1);
    endtask

    task automatic t_hold();
        do_reset(1'b0);
        beat_valid = 1'b1; beat_ready = 1'b0; start_code = 2'b01; beat_keep = 16'hffff;
        @(negedge clk);
        beat_keep = 16'hfff0;
        @(negedge clk);
        chk("R10 change while stalled", 32'(err_flags), 32'h400);
        chk("R10 change code", 32'(err_code), 10);
        do_reset(1'b0);
        beat_valid = 1'b1; beat_ready = 1'b0; abort = 1'b1; start_code = 2'b00;
        @(negedge clk);
        abort = 1'b0;
        @(negedge clk);
        chk("R10 abort dropped while stalled", 32'(err_flags), 32'h800);
        do_reset(1'b0);
        beat_valid = 1'b1; beat_ready = 1'b0; start_code = 2'b01;
        @(negedge clk);
        beat_valid = 1'b0;
        @(negedge clk);
        chk("R10 valid dropped", 32'(err_flags), 32'h400);
    endtask

    task automatic t_clear();
        do_reset(1'b0);
        ns_beat(1'b0, 16'h00f0, 1'b1, 1'b0);
        chk("R12 two rules at once", 32'(err_flags), 32'h090);
        chk("R12 lowest index code", 32'(err_code), 4);
        ns_beat(1'b0, 16'hffff, 1'b1, 1'b0);
        chk("R12 sticky bits kept", 32'(err_flags), 32'h090);
        chk("R12 code follows newest", 32'(err_code), 7);
        chk("R12 any flag", 32'(err_any), 1);
        clr_err = 1'b1;
        ns_beat(1'b0, 16'h00f0, 1'b1, 1'b0);
        clr_err = 1'b0;
        chk("R12 clear wins flags", 32'(err_flags), 0);
        chk("R12 clear wins code", 32'(err_code), 0);
        @(negedge clk);
        chk("R12 stays clear", 32'(err_flags), 0);
    endtask

    initial begin
        rst_n = 1'b0; straddle_en = 1'b0; beat_data = '0; idle();
        t_reset();
        t_ns_frames();
        t_ns_errors();
        t_stall_gate();
        t_st_frames();
        t_st_codes();
        t_st_balance();
        t_abort();
        t_hold();
        t_clear();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule